// File: doc/BRIEF.md
# Multi-Stack Control Flow Sequencer

This block works out the program counter of a shader core one instruction at a time. It holds the PC. On every retired instruction (`step`) it forms the incremented PC and tests it against the top entries of three hardware stacks. A subroutine stack (CALL, 4 deep), a conditional-block stack (IF, 8 deep) and a loop stack (LOOP, 4 deep) are all tested in parallel. Every entry is a pair: a 12-bit match address and a 12-bit destination address. When an entry matches, it is removed and the PC is redirected to its destination.

The IF and LOOP stacks give up at most one entry per instruction. The CALL stack keeps unwinding while each new destination matches the next entry down. The candidate PCs are ranked LOOP, IF, CALL, jump, incremented PC. A jump, whether unconditional or conditional on a boolean constant, takes effect only when no stack popped. Pushing onto a full stack overwrites its oldest entry. A loop break with no open loop puts the block into a hang that only reset clears.

The controller has two states. `ST_RUN` is normal sequencing. `ST_HANG` is the stuck state. There are two transitions. RUN goes to HANG on a step that carries `brk` while the LOOP stack is empty. HANG goes back to RUN only through reset. Every other step in RUN stays in RUN.

Top module: `cfs_sequencer`

## Requirements
- R1: After reset the PC is 0, all three depths are 0 and `hang` is 0.
- R2: With `step` low the PC and all depths hold. A step with no redirect moves the PC to PC+1.
- R3: `jmp_req` sends the PC to `jmp_tgt`. `jmpc_req` does the same only when `jmpc_bool` XOR `jmpc_num0` is 1. When that value is 0 the PC goes to PC+1.
- R4: A jump request is ignored in any step in which some stack pops.
- R5: The IF or LOOP stack pops its top entry when that entry's match address equals PC+1. The PC then goes to the entry's destination, and one entry is removed per step.
- R6: Every stack whose top matches pops. The PC follows LOOP first, then IF, then CALL.
- R7: The CALL stack pops again while the destination just taken equals the match address of the next entry. A chain of 2 or 3 pops lands on the last destination.
- R8: If the CALL stack pops 4 times in one step, all 4 entries are removed. The PC takes the destination of the third pop.
- R9: A push onto a full stack keeps the depth at its maximum and discards the oldest entry.
- R10: A push takes effect after that step's stack checks, so a pushed entry cannot match in the step that pushes it.
- R11: `brk` with a non-empty LOOP stack pops the top LOOP entry. The PC goes to that entry's match address + 1.
- R12: `brk` with an empty LOOP stack enters the hang state. There `hang` is 1, the PC is frozen and steps, pushes and jumps have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction retires this cycle |
| push_call | input | 1 | Push an entry onto the CALL stack |
| call_match | input | 12 | Match address of the CALL entry |
| call_dest | input | 12 | Destination of the CALL entry |
| push_if | input | 1 | Push an entry onto the IF stack |
| if_match | input | 12 | Match address of the IF entry |
| if_dest | input | 12 | Destination of the IF entry |
| push_loop | input | 1 | Push an entry onto the LOOP stack |
| loop_match | input | 12 | Match address of the LOOP entry |
| loop_dest | input | 12 | Destination of the LOOP entry |
| jmp_req | input | 1 | Unconditional jump |
| jmp_tgt | input | 12 | Jump target (shared by both jump kinds) |
| jmpc_req | input | 1 | Jump conditional on a boolean constant |
| jmpc_bool | input | 1 | Value of the boolean constant |
| jmpc_num0 | input | 1 | Bit 0 of the count field, inverts the test |
| brk | input | 1 | Break out of the innermost loop |
| pc | output | 12 | Current program counter |
| call_depth | output | 3 | Entries in the CALL stack |
| if_depth | output | 4 | Entries in the IF stack |
| loop_depth | output | 3 | Entries in the LOOP stack |
| hang | output | 1 | Sequencer is stuck |

## Verification
A wrong stack pointer or count shows up on the depth outputs in the very next cycle. A wrong top entry only shows once its match address comes up: the PC fails to redirect, or redirects to the wrong place, in the step where PC+1 reaches that address. An entry that was overwritten or never removed can stay hidden for several instructions. Because of this, the tests walk each stack empty and then take one more step, so the plain increment that follows proves nothing stale is left.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    localparam int PC_W = 12;

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        pc_t match_pc;
        pc_t dest_pc;
    } fe_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HANG = 1'b1
    } seq_st_e;
endpackage

// File: rtl/cfs_ring_stack.sv
module cfs_ring_stack
    import cfs_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int MAXPOP = 1,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(MAXPOP + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 push,
    input  fe_t                  push_ent,
    input  logic [NW-1:0]        pop_n,
    output fe_t [DEPTH-1:0]      view,
    output logic [CW-1:0]        depth
);
    // Ring storage: wr points at the next free slot, view[0] is the top.
    fe_t            mem [DEPTH];
    logic [PW-1:0]  wr;
    logic [CW-1:0]  cnt;
    logic [PW-1:0]  wr_after_pop;
    logic [CW-1:0]  cnt_after_pop;

    assign wr_after_pop  = wr - PW'(pop_n);
    assign cnt_after_pop = cnt - CW'(pop_n);
    assign depth         = cnt;

    for (genvar j = 0; j < DEPTH; j++) begin : g_view
        assign view[j] = mem[PW'(wr - PW'(j + 1))];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr  <= '0;
            cnt <= '0;
        end else if (en) begin
            if (push) begin
                wr  <= wr_after_pop + PW'(1);
                cnt <= (cnt_after_pop == CW'(DEPTH)) ? CW'(DEPTH) : cnt_after_pop + CW'(1);
            end else begin
                wr  <= wr_after_pop;
                cnt <= cnt_after_pop;
            end
        end
    end

    // Storage carries no reset; a full ring overwrites its oldest slot.
    always_ff @(posedge clk) begin
        if (en && push) begin
            mem[wr_after_pop] <= push_ent;
        end
    end
endmodule

// File: rtl/cfs_call_chain.sv
module cfs_call_chain
    import cfs_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int DROP_AT = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  pc_t              inc_pc,
    input  fe_t [DEPTH-1:0]  view,
    input  logic [CW-1:0]    depth,
    output logic [CW-1:0]    pop_n,
    output pc_t              chain_pc
);
    pc_t  cur;
    pc_t  prev;
    int   n;
    logic live;

    always_comb begin
        cur  = inc_pc;
        prev = inc_pc;
        n    = 0;
        live = 1'b1;
        for (int j = 0; j < DEPTH; j++) begin
            if (live && (CW'(j) < depth) && (view[j].match_pc == cur)) begin
                prev = cur;
                cur  = view[j].dest_pc;
                n    = n + 1;
            end else begin
                live = 1'b0;
            end
        end
        pop_n    = CW'(n);
        // The last update of a chain of DROP_AT pops is lost.
        chain_pc = (n == DROP_AT) ? prev : cur;
    end
endmodule

// File: rtl/cfs_next_pc_arb.sv
module cfs_next_pc_arb
    import cfs_pkg::*;
(
    input  pc_t  inc_pc,
    input  logic loop_hit,
    input  pc_t  loop_pc,
    input  logic if_hit,
    input  pc_t  if_pc,
    input  logic call_hit,
    input  pc_t  call_pc,
    input  logic jmp_take,
    input  pc_t  jmp_pc,
    output pc_t  nxt_pc,
    output logic any_pop
);
    assign any_pop = loop_hit | if_hit | call_hit;

    always_comb begin
        if (loop_hit) begin
            nxt_pc = loop_pc;
        end else if (if_hit) begin
            nxt_pc = if_pc;
        end else if (call_hit) begin
            nxt_pc = call_pc;
        end else if (jmp_take) begin
            nxt_pc = jmp_pc;
        end else begin
            nxt_pc = inc_pc;
        end
    end
endmodule

// File: rtl/cfs_sequencer.sv
module cfs_sequencer
    import cfs_pkg::*;
#(
    parameter int  CALL_DEPTH = 4,
    parameter int  IF_DEPTH   = 8,
    parameter int  LOOP_DEPTH = 4,
    parameter int  CALL_DROP  = 4,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int CCW = $clog2(CALL_DEPTH + 1),
    localparam int ICW = $clog2(IF_DEPTH + 1),
    localparam int LCW = $clog2(LOOP_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             push_call,
    input  logic [PC_W-1:0]  call_match,
    input  logic [PC_W-1:0]  call_dest,
    input  logic             push_if,
    input  logic [PC_W-1:0]  if_match,
    input  logic [PC_W-1:0]  if_dest,
    input  logic             push_loop,
    input  logic [PC_W-1:0]  loop_match,
    input  logic [PC_W-1:0]  loop_dest,
    input  logic             jmp_req,
    input  logic [PC_W-1:0]  jmp_tgt,
    input  logic             jmpc_req,
    input  logic             jmpc_bool,
    input  logic             jmpc_num0,
    input  logic             brk,
    output logic [PC_W-1:0]  pc,
    output logic [CCW-1:0]   call_depth,
    output logic [ICW-1:0]   if_depth,
    output logic [LCW-1:0]   loop_depth,
    output logic             hang
);
    seq_st_e st, st_nxt;

    pc_t  pc_q;
    pc_t  inc_pc;
    pc_t  nxt_pc;
    logic hang_trig;
    logic advance;
    logic jmp_take;
    logic any_pop;

    fe_t [CALL_DEPTH-1:0] call_view;
    fe_t [IF_DEPTH-1:0]   if_view;
    fe_t [LOOP_DEPTH-1:0] loop_view;

    logic [CCW-1:0] call_pop_n;
    pc_t            call_pc;
    logic           call_hit;
    logic           if_hit;
    logic           loop_match_hit;
    logic           loop_pop;
    pc_t            loop_pc;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_RUN;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_RUN:  st_nxt = hang_trig ? ST_HANG : ST_RUN;
            ST_HANG: st_nxt = ST_HANG;
            default: st_nxt = ST_RUN;
        endcase
    end

    // ---------------- outputs and step qualifiers ----------------
    always_comb begin
        hang      = (st == ST_HANG);
        hang_trig = (st == ST_RUN) && step && brk && (loop_depth == '0);
        advance   = (st == ST_RUN) && step && !hang_trig;
        pc        = pc_q;
    end

    assign inc_pc   = pc_q + PC_W'(1);
    assign jmp_take = jmp_req | (jmpc_req & (jmpc_bool ^ jmpc_num0));

    // ---------------- stack checks ----------------
    assign if_hit         = (if_depth != '0) && (if_view[0].match_pc == inc_pc);
    assign loop_match_hit = (loop_depth != '0) && (loop_view[0].match_pc == inc_pc);
    assign loop_pop       = (loop_depth != '0) && (brk || loop_match_hit);
    assign loop_pc        = brk ? (loop_view[0].match_pc + PC_W'(1)) : loop_view[0].dest_pc;
    assign call_hit       = (call_pop_n != '0);

    cfs_ring_stack #(.DEPTH(CALL_DEPTH), .MAXPOP(CALL_DEPTH)) u_call_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (advance),
        .push     (push_call),
        .push_ent ({call_match, call_dest}),
        .pop_n    (call_pop_n),
        .view     (call_view),
        .depth    (call_depth)
    );

    cfs_ring_stack #(.DEPTH(IF_DEPTH), .MAXPOP(1)) u_if_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (advance),
        .push     (push_if),
        .push_ent ({if_match, if_dest}),
        .pop_n    (if_hit),
        .view     (if_view),
        .depth    (if_depth)
    );

    cfs_ring_stack #(.DEPTH(LOOP_DEPTH), .MAXPOP(1)) u_loop_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (advance),
        .push     (push_loop),
        .push_ent ({loop_match, loop_dest}),
        .pop_n    (loop_pop),
        .view     (loop_view),
        .depth    (loop_depth)
    );

    cfs_call_chain #(.DEPTH(CALL_DEPTH), .DROP_AT(CALL_DROP)) u_chain (
        .inc_pc   (inc_pc),
        .view     (call_view),
        .depth    (call_depth),
        .pop_n    (call_pop_n),
        .chain_pc (call_pc)
    );

    cfs_next_pc_arb u_arb (
        .inc_pc   (inc_pc),
        .loop_hit (loop_pop),
        .loop_pc  (loop_pc),
        .if_hit   (if_hit),
        .if_pc    (if_view[0].dest_pc),
        .call_hit (call_hit),
        .call_pc  (call_pc),
        .jmp_take (jmp_take),
        .jmp_pc   (jmp_tgt),
        .nxt_pc   (nxt_pc),
        .any_pop  (any_pop)
    );

    // ---------------- program counter ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (advance) begin
            pc_q <= nxt_pc;
        end
    end
endmodule

// File: rtl/cfs_sequencer_chk.sv
module cfs_sequencer_chk #(
    parameter int CALL_DEPTH = 4,
    parameter int IF_DEPTH   = 8,
    parameter int LOOP_DEPTH = 4,
    parameter int PW  = 12,
    parameter int CCW = 3,
    parameter int ICW = 4,
    parameter int LCW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           step,
    input logic           brk,
    input logic           jmp_req,
    input logic [PW-1:0]  jmp_tgt,
    input logic [PW-1:0]  pc,
    input logic           hang,
    input logic [CCW-1:0] call_depth,
    input logic [ICW-1:0] if_depth,
    input logic [LCW-1:0] loop_depth,
    input logic           any_pop,
    input logic           loop_pop,
    input logic [PW-1:0]  loop_pc
);
    // R12
    hang_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hang |=> hang && $stable(pc) && $stable(call_depth));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc) && $stable(call_depth) && $stable(if_depth) && $stable(loop_depth));

    // R4
    jump_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !hang && !brk && jmp_req && !any_pop |=> pc == $past(jmp_tgt));

    // R6
    loop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !hang && loop_pop |=> pc == $past(loop_pc));

    // R9
    depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_depth <= CCW'(CALL_DEPTH)) && (if_depth <= ICW'(IF_DEPTH)) && (loop_depth <= LCW'(LOOP_DEPTH)));
endmodule

bind cfs_sequencer cfs_sequencer_chk #(
    .CALL_DEPTH (CALL_DEPTH),
    .IF_DEPTH   (IF_DEPTH),
    .LOOP_DEPTH (LOOP_DEPTH),
    .PW         (cfs_pkg::PC_W),
    .CCW        (CCW),
    .ICW        (ICW),
    .LCW        (LCW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .brk        (brk),
    .jmp_req    (jmp_req),
    .jmp_tgt    (jmp_tgt),
    .pc         (pc),
    .hang       (hang),
    .call_depth (call_depth),
    .if_depth   (if_depth),
    .loop_depth (loop_depth),
    .any_pop    (any_pop),
    .loop_pop   (loop_pop),
    .loop_pc    (loop_pc)
);

// File: tb/sim_cfs_sequencer.sv
`timescale 1ns/1ps
module sim_cfs_sequencer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        step;
    logic        push_call, push_if, push_loop;
    logic [11:0] call_match, call_dest, if_match, if_dest, loop_match, loop_dest;
    logic        jmp_req, jmpc_req, jmpc_bool, jmpc_num0, brk;
    logic [11:0] jmp_tgt;
    logic [11:0] pc;
    logic [2:0]  call_depth;
    logic [3:0]  if_depth;
    logic [2:0]  loop_depth;
    logic        hang;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cfs_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .step(step),
        .push_call(push_call), .call_match(call_match), .call_dest(call_dest),
        .push_if(push_if), .if_match(if_match), .if_dest(if_dest),
        .push_loop(push_loop), .loop_match(loop_match), .loop_dest(loop_dest),
        .jmp_req(jmp_req), .jmp_tgt(jmp_tgt),
        .jmpc_req(jmpc_req), .jmpc_bool(jmpc_bool), .jmpc_num0(jmpc_num0),
        .brk(brk), .pc(pc), .call_depth(call_depth), .if_depth(if_depth),
        .loop_depth(loop_depth), .hang(hang)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        step = 0; push_call = 0; push_if = 0; push_loop = 0;
        call_match = 0; call_dest = 0; if_match = 0; if_dest = 0;
        loop_match = 0; loop_dest = 0; jmp_req = 0; jmp_tgt = 0;
        jmpc_req = 0; jmpc_bool = 0; jmpc_num0 = 0; brk = 0;
    endtask

    // Inputs are set at a falling edge; one rising edge; back at falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    task automatic jump_step(logic [11:0] t);
        step = 1; jmp_req = 1; jmp_tgt = t;
        tick();
    endtask

    task automatic call_push_at(logic [11:0] here, logic [11:0] m, logic [11:0] d);
        step = 1; jmp_req = 1; jmp_tgt = here;
        push_call = 1; call_match = m; call_dest = d;
        tick();
    endtask

    task automatic t_reset();
        clr();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 pc", pc, 0);
        chk("R1 depths", {call_depth, if_depth, loop_depth}, 0);
        chk("R1 hang", hang, 0);
    endtask

    task automatic t_plain();
        tick();
        chk("R2 idle pc", pc, 0);
        step = 1; tick();
        chk("R2 increment", pc, 1);
    endtask

    task automatic t_jumps();
        jump_step(12'h0FF);
        chk("R3 jmp", pc, 12'h0FF);
        step = 1; jmpc_req = 1; jmpc_bool = 1; jmpc_num0 = 1; jmp_tgt = 12'h333; tick();
        chk("R3 cond inverted not taken", pc, 12'h100);
        step = 1; jmpc_req = 1; jmpc_bool = 0; jmpc_num0 = 1; jmp_tgt = 12'h0FF; tick();
        chk("R3 cond inverted taken", pc, 12'h0FF);
    endtask

    task automatic t_if();
        step = 1; push_if = 1; if_match = 12'h100; if_dest = 12'h180; tick();
        chk("R10 push not checked same step", pc, 12'h100);
        chk("R10 if depth", if_depth, 1);
        jump_step(12'h0FF);
        chk("R5 no match keeps entry", if_depth, 1);
        step = 1; jmp_req = 1; jmp_tgt = 12'h222; tick();
        chk("R5 if pop pc / R4 jump ignored", pc, 12'h180);
        chk("R5 if depth", if_depth, 0);
    endtask

    task automatic t_prio();
        step = 1; jmp_req = 1; jmp_tgt = 12'h200;
        push_loop = 1; loop_match = 12'h201; loop_dest = 12'h1A0;
        push_if = 1; if_match = 12'h201; if_dest = 12'h1B0;
        push_call = 1; call_match = 12'h201; call_dest = 12'h1C0;
        tick();
        chk("R6 setup pc", pc, 12'h200);
        step = 1; tick();
        chk("R6 loop wins", pc, 12'h1A0);
        chk("R6 all matching popped", {call_depth, if_depth, loop_depth}, 0);
    endtask

    task automatic t_chain3();
        call_push_at(12'h300, 12'h502, 12'h600);
        call_push_at(12'h300, 12'h402, 12'h502);
        call_push_at(12'h300, 12'h301, 12'h402);
        chk("R7 depth", call_depth, 3);
        step = 1; tick();
        chk("R7 chain pc", pc, 12'h600);
        chk("R7 chain emptied", call_depth, 0);
    endtask

    task automatic t_chain4();
        call_push_at(12'h600, 12'h704, 12'h7F0);
        call_push_at(12'h600, 12'h703, 12'h704);
        call_push_at(12'h600, 12'h702, 12'h703);
        call_push_at(12'h600, 12'h601, 12'h702);
        chk("R8 depth", call_depth, 4);
        step = 1; tick();
        chk("R8 fourth update dropped", pc, 12'h704);
        chk("R8 all removed", call_depth, 0);
    endtask

    task automatic t_overflow();
        call_push_at(12'h020, 12'h011, 12'h0EE);
        for (int k = 0; k < 4; k++) call_push_at(12'h020, 12'h011, 12'h010);
        chk("R9 depth saturates", call_depth, 4);
        jump_step(12'h010);
        for (int k = 0; k < 4; k++) begin
            step = 1; tick();
            chk("R9 pop pc", pc, 12'h010);
        end
        chk("R9 emptied", call_depth, 0);
        step = 1; tick();
        chk("R9 oldest discarded", pc, 12'h011);
    endtask

    task automatic t_break();
        step = 1; push_loop = 1; loop_match = 12'h050; loop_dest = 12'h040; tick();
        chk("R11 pushed", loop_depth, 1);
        step = 1; brk = 1; tick();
        chk("R11 break pc", pc, 12'h051);
        chk("R11 loop popped", loop_depth, 0);
        chk("R11 no hang", hang, 0);
    endtask

    task automatic t_hang();
        step = 1; brk = 1; tick();
        chk("R12 hang set", hang, 1);
        chk("R12 pc held", pc, 12'h051);
        step = 1; push_call = 1; call_match = 12'h1; call_dest = 12'h2;
        jmp_req = 1; jmp_tgt = 12'h444; tick();
        chk("R12 step ignored", pc, 12'h051);
        chk("R12 push ignored", call_depth, 0);
        chk("R12 still hung", hang, 1);
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        chk("R12 reset clears hang", hang, 0);
        chk("R1 reset pc", pc, 0);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_jumps();
        t_if();
        t_prio();
        t_chain3();
        t_chain4();
        t_overflow();
        t_break();
        t_hang();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule